// File: doc/BRIEF.md
# Atomic Prefix Legality Checker

This block sits behind an x86 instruction decoder that has already split an instruction into its prefix flags, opcode map, primary opcode byte and ModRM byte. It decides whether the bus-lock prefix (F0) and the elision hint prefixes (F2 used as acquire, F3 used as release) are legal on that instruction. It then reports an undefined-opcode fault, an effective bus-lock request, and the acquire and release elision hints that the memory pipeline should see.

The decision is combinational. An opcode classifier produces a small set of strobes that describe the instruction. A verdict datapath combines those strobes with the prefix flags. With the default parameter setting the four outputs pass through one register stage, so they follow the inputs by one clock.

Scanning the prefix bytes, computing operand addresses and carrying out the atomic read-modify-write are the job of other blocks.

Top module: `atomic_pfx_check`

## Requirements
- R1: While `rstN` is low, the registered outputs `udFault`, `busLock`, `hintAcquire` and `hintRelease` are all 0, whatever the inputs are.
- R2: With the lock flag set and the destination in memory (ModRM mod != 3), these instructions are legal: the fault is 0 and `busLock` is 1.
  - One-byte map: 00/01, 08/09, 10/11, 18/19, 20/21, 28/29 and 30/31.
  - One-byte map: 80/81/83 with ModRM reg 0..6.
  - One-byte map: F6/F7 with reg 2 or 3, and FE/FF with reg 0 or 1.
  - One-byte map: XCHG 86/87.
  - 0F map: AB, B3, BB, B0/B1 and C0/C1.
  - 0F map: BA with reg 5..7, and C7 with reg 1.
- R3: The lock flag together with ModRM mod = 3 on any of the R2 opcodes gives `udFault`=1 and `busLock`=0. Examples are FF C0 and 0F C1 D8.
- R4: The lock flag on any opcode outside the R2 list gives `udFault`=1. This includes MOV 89, MOV B8, 80 with reg 7, and the memory-source ALU form 03. Without the lock flag these opcodes give all outputs 0.
- R5: XCHG 86/87 with a memory operand drives `busLock`=1 even when the lock flag is clear. Register-form XCHG never locks.
- R6: F2 or F3 produces a hint only in two cases: with a legal lock, or on memory-form XCHG without the lock flag. F2 or F3 on register-form XCHG (for example 87 D9) gives no fault and no hint. F3 on a lockable instruction without the lock flag gives no hint.
- R7: When both F2 and F3 are present, the one that came last wins. Input `repLastF3`=1 means F3 came last and selects release; `repLastF3`=0 selects acquire. `hintAcquire` and `hintRelease` are never 1 together.
- R8: F3 without the lock flag gives `hintRelease`=1 with `busLock`=0 on the MOV memory stores 88/89 and C6/C7 with reg 0 and mod != 3. F2 on these forms, and F3 on their register forms, give no hint.
- R9: Opcode 82 follows the rules of 80 when `longMode`=0. When `longMode`=1, opcode 82 with the lock flag faults.
- R10: The lock flag on any VEX-encoded instruction (`vexEnc`=1) gives `udFault`=1.
- R11: Whenever `udFault` is 1, `busLock`, `hintAcquire` and `hintRelease` are 0. An example is lock plus F3 on MOV 89 18.
- R12: With OUT_REG=1 (the default), a change on the inputs shows on the outputs after exactly one rising clock edge. With OUT_REG=0 the outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rstN | input | 1 | Active-low synchronous reset |
| pfxLock | input | 1 | F0 prefix seen |
| pfxF2 | input | 1 | F2 prefix seen |
| pfxF3 | input | 1 | F3 prefix seen |
| repLastF3 | input | 1 | F3 came after F2 (used when both are set) |
| longMode | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| map0F | input | 1 | Opcode is in the 0F map |
| vexEnc | input | 1 | Instruction is VEX-encoded |
| opByte | input | 8 | Primary opcode byte |
| modrm | input | 8 | ModRM byte (mod in [7:6], reg in [5:3]) |
| udFault | output | 1 | Undefined-opcode fault from an illegal lock |
| busLock | output | 1 | Effective bus-lock request |
| hintAcquire | output | 1 | Acquire elision hint |
| hintRelease | output | 1 | Release elision hint |

## Verification
Assertions check three rules on every cycle:
- The classifier never marks a VEX-encoded or register-destination instruction as lockable or as an implicit-lock or store form.
- A fault always masks the lock request and both hints.
- The two hints are exclusive, and memory-form XCHG always locks.

Only the directed scenarios can show that each opcode and group field falls into the right class. The same holds for the 82-versus-mode rule, the handling of both repeat prefixes together, the MOV release-only path and the one-cycle latency, because these depend on the exact encoding tables.

// File: rtl/atomic_pfx_pkg.sv
package atomic_pfx_pkg;
  localparam int OP_W    = 8;
  localparam int MOD_MSB = 7;
  localparam int MOD_LSB = 6;
  localparam int REG_MSB = 5;
  localparam int REG_LSB = 3;
  localparam logic [1:0] MOD_REGISTER = 2'b11;

  typedef logic [OP_W-1:0] opByte_t;

  // strobes from classifier to verdict datapath
  typedef struct packed {
    logic lockOk;    // lockable opcode with memory destination
    logic xchgMem;   // XCHG with memory operand (implicit lock)
    logic movStore;  // MOV store to memory (release-only hint)
  } ctlStrobes_t;

  typedef struct packed {
    logic udFault;
    logic busLock;
    logic hintAcq;
    logic hintRel;
  } verdict_t;
endpackage

// File: rtl/atomic_pfx_ctl.sv
module atomic_pfx_ctl
  import atomic_pfx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        longMode,
  input  logic        map0F,
  input  logic        vexEnc,
  input  opByte_t     opByte,
  input  opByte_t     modrm,
  output ctlStrobes_t strobes
);
  logic [1:0] modF;
  logic [2:0] regF;
  logic memDest, aluRmw, lockOne, lockTwo, isXchg, isMovSt;

  assign modF = modrm[MOD_MSB:MOD_LSB];
  assign regF = modrm[REG_MSB:REG_LSB];
  assign memDest = (modF != MOD_REGISTER);
  // 00..31 rows, columns 0/1, excluding the compare row 38/39
  assign aluRmw = (opByte[7:6] == 2'b00) && (opByte[2:1] == 2'b00) && (opByte[5:3] != 3'd7);

  always_comb begin
    lockOne = 1'b0;
    isXchg  = 1'b0;
    isMovSt = 1'b0;
    case (opByte)
      8'h80, 8'h81, 8'h83: lockOne = (regF != 3'd7);
      8'h82:               lockOne = !longMode && (regF != 3'd7);
      8'h86, 8'h87: begin lockOne = 1'b1; isXchg = 1'b1; end
      8'hF6, 8'hF7:        lockOne = (regF == 3'd2) || (regF == 3'd3);
      8'hFE, 8'hFF:        lockOne = (regF == 3'd0) || (regF == 3'd1);
      8'h88, 8'h89:        isMovSt = 1'b1;
      8'hC6, 8'hC7:        isMovSt = (regF == 3'd0);
      default:             lockOne = aluRmw;
    endcase
  end

  always_comb begin
    case (opByte)
      8'hAB, 8'hB3, 8'hBB, 8'hB0, 8'hB1, 8'hC0, 8'hC1: lockTwo = 1'b1;
      8'hBA:   lockTwo = (regF >= 3'd5);
      8'hC7:   lockTwo = (regF == 3'd1);
      default: lockTwo = 1'b0;
    endcase
  end

  always_comb begin
    strobes.lockOk   = !vexEnc && memDest && (map0F ? lockTwo : lockOne);
    strobes.xchgMem  = !vexEnc && !map0F && memDest && isXchg;
    strobes.movStore = !vexEnc && !map0F && memDest && isMovSt;
  end

  assert_vex_not_lockable_R10: assert property (@(posedge clk) disable iff (!rstN)
    vexEnc |-> !strobes.lockOk && !strobes.xchgMem && !strobes.movStore);
  assert_regdest_not_lockable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modrm[MOD_MSB:MOD_LSB] == MOD_REGISTER) |-> !strobes.lockOk && !strobes.xchgMem);
  assert_store_not_lockable_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.movStore |-> !strobes.lockOk);
endmodule

// File: rtl/atomic_pfx_dp.sv
module atomic_pfx_dp
  import atomic_pfx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pfxLock,
  input  logic        pfxF2,
  input  logic        pfxF3,
  input  logic        repLastF3,
  input  ctlStrobes_t strobes,
  output verdict_t    verdict
);
  logic fault, lockLegal, hintPath, acqSel, relSel;

  assign fault     = pfxLock && !strobes.lockOk;
  assign lockLegal = pfxLock && strobes.lockOk;
  assign hintPath  = lockLegal || strobes.xchgMem;
  // last repeat prefix wins when both are present
  assign acqSel = pfxF2 && (!pfxF3 || !repLastF3);
  assign relSel = pfxF3 && (!pfxF2 || repLastF3);

  always_comb begin
    verdict.udFault = fault;
    verdict.busLock = !fault && hintPath;
    verdict.hintAcq = !fault && acqSel && hintPath;
    verdict.hintRel = !fault && relSel && (hintPath || strobes.movStore);
  end

  assert_fault_masks_R11: assert property (@(posedge clk) disable iff (!rstN)
    verdict.udFault |-> !verdict.busLock && !verdict.hintAcq && !verdict.hintRel);
  assert_hint_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(verdict.hintAcq && verdict.hintRel));
  assert_xchg_implicit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.xchgMem && !pfxLock) |-> verdict.busLock);
  assert_acq_needs_lock_R6: assert property (@(posedge clk) disable iff (!rstN)
    verdict.hintAcq |-> verdict.busLock);
endmodule

// File: rtl/atomic_pfx_check.sv
module atomic_pfx_check
  import atomic_pfx_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pfxLock,
  input  logic       pfxF2,
  input  logic       pfxF3,
  input  logic       repLastF3,
  input  logic       longMode,
  input  logic       map0F,
  input  logic       vexEnc,
  input  logic [7:0] opByte,
  input  logic [7:0] modrm,
  output logic       udFault,
  output logic       busLock,
  output logic       hintAcquire,
  output logic       hintRelease
);
  ctlStrobes_t strobes;
  verdict_t    verdictC, verdictQ;

  atomic_pfx_ctl ctl_i (
    .clk(clk), .rstN(rstN), .longMode(longMode), .map0F(map0F),
    .vexEnc(vexEnc), .opByte(opByte), .modrm(modrm), .strobes(strobes)
  );

  atomic_pfx_dp dp_i (
    .clk(clk), .rstN(rstN), .pfxLock(pfxLock), .pfxF2(pfxF2), .pfxF3(pfxF3),
    .repLastF3(repLastF3), .strobes(strobes), .verdict(verdictC)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) verdictQ <= '0;
        else       verdictQ <= verdictC;
      end
    end else begin : g_comb
      assign verdictQ = verdictC;
    end
  endgenerate

  assign udFault     = verdictQ.udFault;
  assign busLock     = verdictQ.busLock;
  assign hintAcquire = verdictQ.hintAcq;
  assign hintRelease = verdictQ.hintRel;
endmodule

// File: tb/atomic_pfx_check_tb_top.sv
`timescale 1ns/1ps
module atomic_pfx_check_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pfxLock = 0, pfxF2 = 0, pfxF3 = 0, repLastF3 = 0;
  logic longMode = 1, map0F = 0, vexEnc = 0;
  logic [7:0] opByte = 8'h90, modrm = 8'h00;
  logic udFault, busLock, hintAcquire, hintRelease;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  atomic_pfx_check dut_i (
    .clk(clk), .rstN(rstN), .pfxLock(pfxLock), .pfxF2(pfxF2), .pfxF3(pfxF3),
    .repLastF3(repLastF3), .longMode(longMode), .map0F(map0F), .vexEnc(vexEnc),
    .opByte(opByte), .modrm(modrm), .udFault(udFault), .busLock(busLock),
    .hintAcquire(hintAcquire), .hintRelease(hintRelease)
  );

  // expected vector order: {fault, lock, acquire, release}
  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] got;
    got = {udFault, busLock, hintAcquire, hintRelease};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic l, f2, f3, last, lm, m0f, vex,
                       input logic [7:0] op, mr);
    pfxLock = l; pfxF2 = f2; pfxF3 = f3; repLastF3 = last;
    longMode = lm; map0F = m0f; vexEnc = vex; opByte = op; modrm = mr;
  endtask

  task automatic run(input string tag, input logic l, f2, f3, last, lm, m0f, vex,
                     input logic [7:0] op, mr, input logic [3:0] exp);
    @(negedge clk);
    drive(l, f2, f3, last, lm, m0f, vex, op, mr);
    @(negedge clk);
    chk(tag, exp);
  endtask

  task automatic test_reset_R1();
    drive(1, 1, 0, 0, 1, 0, 0, 8'h87, 8'h19);
    repeat (3) @(negedge clk);
    chk("R1", 4'b0000);
    rstN = 1'b1;
  endtask

  task automatic test_lockable_R2();
    run("R2 FF/0", 1,0,0,0, 1,0,0, 8'hFF, 8'h00, 4'b0100);
    run("R2 0F C1", 1,0,0,0, 1,1,0, 8'hC1, 8'h18, 4'b0100);
    run("R2 0F C7/1", 1,0,0,0, 1,1,0, 8'hC7, 8'h08, 4'b0100);
    run("R2 0F BA/5", 1,0,0,0, 1,1,0, 8'hBA, 8'h28, 4'b0100);
    run("R2 00", 1,0,0,0, 1,0,0, 8'h00, 8'h00, 4'b0100);
    run("R2 F7/3", 1,0,0,0, 1,0,0, 8'hF7, 8'h18, 4'b0100);
  endtask

  task automatic test_regdest_R3();
    run("R3 FF C0", 1,0,0,0, 1,0,0, 8'hFF, 8'hC0, 4'b1000);
    run("R3 0F C1 D8", 1,0,0,0, 1,1,0, 8'hC1, 8'hD8, 4'b1000);
  endtask

  task automatic test_nonlockable_R4();
    run("R4 89", 1,0,0,0, 1,0,0, 8'h89, 8'h18, 4'b1000);
    run("R4 B8", 1,0,0,0, 1,0,0, 8'hB8, 8'h01, 4'b1000);
    run("R4 80/7", 1,0,0,0, 1,0,0, 8'h80, 8'h38, 4'b1000);
    run("R4 03", 1,0,0,0, 1,0,0, 8'h03, 8'h00, 4'b1000);
    run("R4 B8 nolock", 0,0,0,0, 1,0,0, 8'hB8, 8'h01, 4'b0000);
  endtask

  task automatic test_xchg_R5();
    run("R5 87 mem", 0,0,0,0, 1,0,0, 8'h87, 8'h19, 4'b0100);
    run("R5 87 reg", 0,0,0,0, 1,0,0, 8'h87, 8'hD9, 4'b0000);
    run("R5 lock 87 reg", 1,0,0,0, 1,0,0, 8'h87, 8'hD9, 4'b1000);
  endtask

  task automatic test_hints_R6();
    run("R6 lock F2 FF", 1,1,0,0, 1,0,0, 8'hFF, 8'h00, 4'b0110);
    run("R6 F3 FF nolock", 0,0,1,0, 1,0,0, 8'hFF, 8'h00, 4'b0000);
    run("R6 F2 87 mem", 0,1,0,0, 1,0,0, 8'h87, 8'h19, 4'b0110);
    run("R6 F2 87 reg", 0,1,0,0, 1,0,0, 8'h87, 8'hD9, 4'b0000);
  endtask

  task automatic test_order_R7();
    run("R7 F2 last", 1,1,1,0, 1,0,0, 8'h87, 8'h19, 4'b0110);
    run("R7 F3 last", 1,1,1,1, 1,0,0, 8'h87, 8'h19, 4'b0101);
  endtask

  task automatic test_movrel_R8();
    run("R8 F3 89", 0,0,1,0, 1,0,0, 8'h89, 8'h18, 4'b0001);
    run("R8 F3 C6/0", 0,0,1,0, 1,0,0, 8'hC6, 8'h00, 4'b0001);
    run("R8 F2 89", 0,1,0,0, 1,0,0, 8'h89, 8'h18, 4'b0000);
    run("R8 F3 89 reg", 0,0,1,0, 1,0,0, 8'h89, 8'hD8, 4'b0000);
  endtask

  task automatic test_op82_R9();
    run("R9 82 32bit", 1,0,0,0, 0,0,0, 8'h82, 8'h00, 4'b0100);
    run("R9 82 64bit", 1,0,0,0, 1,0,0, 8'h82, 8'h00, 4'b1000);
  endtask

  task automatic test_vex_R10();
    run("R10 vex 6F", 1,0,0,0, 1,0,1, 8'h6F, 8'hC1, 4'b1000);
    run("R10 vex FF mem", 1,0,0,0, 1,0,1, 8'hFF, 8'h00, 4'b1000);
  endtask

  task automatic test_mask_R11();
    run("R11 lock F3 89", 1,0,1,0, 1,0,0, 8'h89, 8'h18, 4'b1000);
  endtask

  task automatic test_latency_R12();
    run("R12 setup", 0,0,0,0, 1,0,0, 8'h90, 8'h00, 4'b0000);
    @(negedge clk);
    drive(1,0,0,0, 1,0,0, 8'hFF, 8'h00);
    #1;
    chk("R12 before edge", 4'b0000);
    @(negedge clk);
    chk("R12 after edge", 4'b0100);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    test_reset_R1();
    test_lockable_R2();
    test_regdest_R3();
    test_nonlockable_R4();
    test_xchg_R5();
    test_hints_R6();
    test_order_R7();
    test_movrel_R8();
    test_op82_R9();
    test_vex_R10();
    test_mask_R11();
    test_latency_R12();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule